// File: doc/BRIEF.md
# Configurable Burst Read Sequencer

This block is the read side of a synchronous NOR-style memory device. A host pulses an active-low address-valid strobe while chip enable is low. The block latches the start address and waits a programmed number of clocks. It then drives one 16-bit word per clock from an internal word array. While it waits, a WAIT flag marks the data bus as not valid.

A 16-bit read-configuration register sets the access. It selects synchronous burst mode or asynchronous page mode, the first-access latency and the burst length. It also selects whether word addresses wrap inside the burst-length boundary or run on linearly. An optional two-clock data hold stretches every word. A write that carries an unsupported combination is refused and flagged. Each new strobe takes a snapshot of the configuration, so a write during a burst only affects the next burst.

The array contents are computed, not stored, so a bench can predict every word from its address. In page mode the host selects the word inside a four-word page directly with the two low address pins.

Top module: `burst_read_seq`

## Requirements
- R1: After reset, cfg_rdata reads 0x980F, cfg_err is 0, dq_oe is 0, wait_o is 0 and dq_out is 0. This value means: bit 15 = 1 (page mode), bits 13:11 = 011 (latency 3), bit 3 = 1 (linear), bits 2:0 = 111 (continuous).
- R2: Bits 14, 10 and 7:4 of the register always read 0. An accepted write stores bits 15, 13:11, 9, 8, 3 and 2:0 and drops the bits it cannot hold.
- R3: A write is refused when any of these holds: bits 13:11 lie outside 2..5; bits 2:0 are not 001, 010, 011 or 111; or bits 13:11 = 010 with bit 9 and bit 8 both set. A refused write leaves the register unchanged and sets cfg_err to 1 from the next cycle. cfg_err stays 1 until the next accepted write. Later bursts use the old setting.
- R4: Call E0 the rising edge at which adv_n = 0 and ce_n = 0 are sampled, and L the value of bits 13:11. After edges E0 to E(L-1), wait_o = 1 and dq_oe = 0. The first word is driven after edge EL.
- R5: Bits 2:0 set the burst length N: 001 gives 4 words, 010 gives 8 and 011 gives 16. With bit 3 = 0 and a finite N, word k comes from address (S with its low log2 N bits cleared) + ((S + k) mod N), where S is the start address.
- R6: With bit 3 = 1 and a finite N, word k comes from (S + k) mod 2^ADDR_W. A finite burst drives exactly N words in either wrap mode. After the last word, dq_oe and wait_o both return to 0. dq_out is 0 whenever dq_oe is 0.
- R7: With bits 2:0 = 111, the burst is continuous and linear whatever bit 3 holds. It runs until ce_n is sampled high. One clock after ce_n is sampled high, dq_oe and wait_o are both 0.
- R8: With bit 9 = 1 in synchronous mode, each word stays on dq_out for two clocks.
- R9: With bit 15 = 1, once the latency has elapsed dq_out shows the word at {latched address upper bits, addr[1:0]}, taken combinationally from the live addr pins. This continues until ce_n rises, whatever bits 2:0 hold.
- R10: A strobe during a burst or during the latency count aborts it. The latency count restarts from that edge with the new address.
- R11: The word at array address a is (a * 40503 mod 65536) XOR 0xC3A5.
- R12: wait_o is 0 on every clock that carries a valid word, and 1 on every latency clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| adv_n | input | 1 | Active-low address-valid strobe |
| addr | input | ADDR_W | Word address; low two bits select the page word in page mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Current configuration value |
| cfg_err | output | 1 | Last configuration write was refused |
| dq_out | output | 16 | Read data, 0 when not enabled |
| dq_oe | output | 1 | Data bus drive enable (stands for leaving high impedance) |
| wait_o | output | 1 | High while the data bus does not carry valid data |

## Verification
The bench sweeps every legal latency, both wrap modes, all three finite lengths and several start offsets. The offsets include ones near the top of the address space. A design that took the wrap window from the wrong bits would escape its aligned block, and a latency counter that was off by one would shift every word by a clock. A second strobe in the middle of a burst must restart the count; a design that ignored it would keep streaming the old addresses. A refused write must leave the old latency in force, and a page-mode read must follow the live low address pins past the nominal burst length instead of ending.

// File: rtl/brs_pkg.sv
package brs_pkg;

  localparam logic [15:0] CFG_KEEP_MASK = 16'hBB0F;
  localparam logic [15:0] CFG_RST_VAL   = 16'h980F;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LAT  = 2'd1,
    ST_DATA = 2'd2
  } seq_st_t;

  typedef struct packed {
    logic       page;
    logic [2:0] lat;
    logic       hold;
    logic       early;
    logic       wrap;
    logic [2:0] blen;
  } rcfg_t;

  function automatic rcfg_t cfg_decode(logic [15:0] v);
    rcfg_t c;
    c.page  = v[15];
    c.lat   = v[13:11];
    c.hold  = v[9];
    c.early = v[8];
    c.wrap  = v[3];
    c.blen  = v[2:0];
    return c;
  endfunction

  function automatic logic [15:0] cfg_encode(rcfg_t c);
    logic [15:0] v;
    v        = '0;
    v[15]    = c.page;
    v[13:11] = c.lat;
    v[9]     = c.hold;
    v[8]     = c.early;
    v[3]     = c.wrap;
    v[2:0]   = c.blen;
    return v;
  endfunction

  function automatic logic cfg_legal(logic [15:0] v);
    logic lat_ok, len_ok, combo_bad;
    lat_ok    = (v[13:11] >= 3'd2) && (v[13:11] <= 3'd5);
    len_ok    = (v[2:0] == 3'b001) || (v[2:0] == 3'b010) ||
                (v[2:0] == 3'b011) || (v[2:0] == 3'b111);
    combo_bad = (v[13:11] == 3'd2) && v[9] && v[8];
    return lat_ok && len_ok && !combo_bad;
  endfunction

  // Words per finite burst; 0 stands for a continuous burst.
  function automatic logic [4:0] burst_len(logic [2:0] blen);
    case (blen)
      3'b001:  return 5'd4;
      3'b010:  return 5'd8;
      3'b011:  return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [15:0] burst_mask(logic [2:0] blen);
    logic [4:0] n;
    n = burst_len(blen);
    return (n == 5'd0) ? 16'h0000 : (16'(n) - 16'd1);
  endfunction

  function automatic logic [15:0] array_word(logic [15:0] a);
    logic [15:0] p;
    p = a * 16'd40503;
    return p ^ 16'hC3A5;
  endfunction

endpackage

// File: rtl/brs_cfg_reg.sv
module brs_cfg_reg
  import brs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        err,
  output logic        o_page,
  output logic [2:0]  o_lat,
  output logic        o_hold,
  output logic        o_wrap,
  output logic [2:0]  o_blen
);

  rcfg_t cfg_q;
  logic  wr_accept;
  logic  wr_reject;

  assign wr_accept = we && cfg_legal(wdata);
  assign wr_reject = we && !cfg_legal(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= cfg_decode(CFG_RST_VAL);
      err   <= 1'b0;
    end else if (wr_accept) begin
      cfg_q <= cfg_decode(wdata);
      err   <= 1'b0;
    end else if (wr_reject) begin
      err   <= 1'b1;
    end
  end

  assign rdata  = cfg_encode(cfg_q);
  assign o_page = cfg_q.page;
  assign o_lat  = cfg_q.lat;
  assign o_hold = cfg_q.hold;
  assign o_wrap = cfg_q.wrap;
  assign o_blen = cfg_q.blen;

  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> $stable(rdata) && err) else $error("refused write changed cfg"); // R3

  AST_ACCEPT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (rdata == ($past(wdata) & CFG_KEEP_MASK)) && !err) else $error("accepted write mismatch"); // R2

endmodule

// File: rtl/brs_word_array.sv
module brs_word_array
  import brs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_word
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [15:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign rom[i] = array_word(16'(i));
  end

  assign rd_word = rom[rd_addr];

endmodule

// File: rtl/brs_addr_gen.sv
module brs_addr_gen
  import brs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              s_page,
  input  logic              s_wrap,
  input  logic [2:0]        s_blen,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] widx,
  input  logic [1:0]        page_sel,
  output logic [ADDR_W-1:0] cur_addr
);

  logic [15:0] b16, k16, mask16, lin16, wrp16;
  logic        finite;

  always_comb begin
    b16    = 16'(base);
    k16    = 16'(widx);
    mask16 = burst_mask(s_blen);
    finite = (burst_len(s_blen) != 5'd0);
    lin16  = b16 + k16;
    wrp16  = (b16 & ~mask16) | (lin16 & mask16);
    if (s_page)
      cur_addr = {base[ADDR_W-1:2], page_sel};
    else if (!s_wrap && finite)
      cur_addr = ADDR_W'(wrp16);
    else
      cur_addr = ADDR_W'(lin16);
  end

endmodule

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import brs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              live_page,
  input  logic [2:0]        live_lat,
  input  logic              live_hold,
  input  logic              live_wrap,
  input  logic [2:0]        live_blen,
  output logic              s_page,
  output logic              s_wrap,
  output logic [2:0]        s_blen,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] widx,
  output logic              data_valid,
  output logic              wait_o
);

  seq_st_t    st;
  logic [2:0] cnt;
  logic       s_hold;
  logic       ph;
  logic       strobe;
  logic       step;
  logic       last_word;
  logic [4:0] n_words;

  assign strobe    = !ce_n && !adv_n;
  assign step      = !s_hold || ph;
  assign n_words   = burst_len(s_blen);
  assign last_word = !s_page && (n_words != 5'd0) &&
                     (widx == ADDR_W'(n_words - 5'd1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      base   <= '0;
      widx   <= '0;
      ph     <= 1'b0;
      s_page <= 1'b1;
      s_hold <= 1'b0;
      s_wrap <= 1'b1;
      s_blen <= 3'b111;
    end else if (ce_n) begin
      st   <= ST_IDLE;
      widx <= '0;
      ph   <= 1'b0;
    end else if (!adv_n) begin
      st     <= ST_LAT;
      cnt    <= live_lat;
      base   <= addr_in;
      widx   <= '0;
      ph     <= 1'b0;
      s_page <= live_page;
      s_hold <= live_hold;
      s_wrap <= live_wrap;
      s_blen <= live_blen;
    end else begin
      case (st)
        ST_LAT: begin
          if (cnt == 3'd1) st <= ST_DATA;
          else             cnt <= cnt - 3'd1;
        end
        ST_DATA: begin
          if (!s_page) begin
            if (!step) begin
              ph <= 1'b1;
            end else begin
              ph   <= 1'b0;
              widx <= widx + 1'b1;
              if (last_word) st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign data_valid = (st == ST_DATA);
  assign wait_o     = (st == ST_LAT);

  AST_LAT_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(wait_o)) else $error("data without latency"); // R4

  AST_STROBE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> wait_o && !data_valid) else $error("strobe did not restart"); // R10

  AST_CE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !wait_o && !data_valid) else $error("chip enable did not abort"); // R7

  AST_HOLD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !s_page && s_hold && !ph && !ce_n && adv_n)
      |=> data_valid && $stable(widx)) else $error("hold word advanced"); // R8

  AST_FINITE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && last_word && step && !ce_n && adv_n)
      |=> !data_valid && !wait_o) else $error("finite burst overran"); // R6

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import brs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  output logic              cfg_err,
  output logic [15:0]       dq_out,
  output logic              dq_oe,
  output logic              wait_o
);

  logic              live_page, live_hold, live_wrap;
  logic [2:0]        live_lat, live_blen;
  logic              s_page, s_wrap;
  logic [2:0]        s_blen;
  logic [ADDR_W-1:0] base, widx, cur_addr;
  logic [15:0]       rd_word;
  logic              data_valid;
  logic [15:0]       win_mask;

  brs_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .err    (cfg_err),
    .o_page (live_page),
    .o_lat  (live_lat),
    .o_hold (live_hold),
    .o_wrap (live_wrap),
    .o_blen (live_blen)
  );

  brs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .adv_n      (adv_n),
    .addr_in    (addr),
    .live_page  (live_page),
    .live_lat   (live_lat),
    .live_hold  (live_hold),
    .live_wrap  (live_wrap),
    .live_blen  (live_blen),
    .s_page     (s_page),
    .s_wrap     (s_wrap),
    .s_blen     (s_blen),
    .base       (base),
    .widx       (widx),
    .data_valid (data_valid),
    .wait_o     (wait_o)
  );

  brs_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .s_page   (s_page),
    .s_wrap   (s_wrap),
    .s_blen   (s_blen),
    .base     (base),
    .widx     (widx),
    .page_sel (addr[1:0]),
    .cur_addr (cur_addr)
  );

  brs_word_array #(.ADDR_W(ADDR_W)) u_array (
    .rd_addr (cur_addr),
    .rd_word (rd_word)
  );

  assign dq_oe    = data_valid;
  assign dq_out   = data_valid ? rd_word : 16'h0000;
  assign win_mask = burst_mask(s_blen);

  AST_WRAP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && !s_page && !s_wrap && (win_mask != 16'h0000))
      |-> (((16'(cur_addr) ^ 16'(base)) & ~win_mask) == 16'h0000)) else $error("wrap left window"); // R5

endmodule

// File: tb/burst_read_seq_bench.sv
module burst_read_seq_bench;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, adv_n, cfg_we;
  logic [AW-1:0] addr;
  logic [15:0]   cfg_wdata, cfg_rdata, dq_out;
  logic          cfg_err, dq_oe, wait_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  burst_read_seq #(.ADDR_W(AW)) u_burst_read_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .addr(addr),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_err(cfg_err), .dq_out(dq_out), .dq_oe(dq_oe), .wait_o(wait_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(int a);
    int p;
    p = (a * 40503) % 65536;
    return 16'(p) ^ 16'hC3A5;
  endfunction

  function automatic logic [15:0] cfgv(int page, int lat, int hold, int early, int wrap, int blen);
    return 16'((page << 15) | (lat << 11) | (hold << 9) | (early << 8) | (wrap << 3) | blen);
  endfunction

  function automatic int len_of(int blen);
    return (blen == 1) ? 4 : (blen == 2) ? 8 : (blen == 3) ? 16 : 0;
  endfunction

  function automatic int exp_addr(int s, int k, int wrap, int n);
    int off;
    if (n == 0 || wrap == 1) return (s + k) % 256;
    off = s % n;
    return (s - off) + ((off + k) % n);
  endfunction

  task automatic write_cfg(logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic strobe(int s);
    @(negedge clk);
    ce_n = 1'b0; adv_n = 1'b0; addr = AW'(s);
    @(negedge clk);
    adv_n = 1'b1; addr = 8'h5C;
  endtask

  task automatic expect_latency(int lat);
    chk("R4 wait during latency", {wait_o, dq_oe}, 2'b10);
    for (int j = 1; j < lat; j++) begin
      @(negedge clk);
      chk("R12 wait high on latency clock", {wait_o, dq_oe}, 2'b10);
    end
  endtask

  task automatic expect_word(string req, int a, int hold);
    for (int h = 0; h <= hold; h++) begin
      @(negedge clk);
      chk("R12 valid word with wait low", {wait_o, dq_oe}, 2'b01);
      chk(req, dq_out, word_of(a));
    end
  endtask

  task automatic run_burst(int s, int lat, int hold, int wrap, int blen, int cnt);
    int n;
    n = len_of(blen);
    strobe(s);
    expect_latency(lat);
    for (int k = 0; k < cnt; k++)
      expect_word((n == 0) ? "R7 continuous word" : (wrap == 0) ? "R5 wrap word" : "R6 linear word",
                  exp_addr(s, k, wrap, n), hold);
    if (n != 0) begin
      @(negedge clk);
      chk("R6 idle after finite burst", {wait_o, dq_oe}, 2'b00);
      chk("R6 dq zero when disabled", dq_out, 16'h0000);
    end
    ce_n = 1'b1;
    @(negedge clk);
    chk("R7 idle after chip enable high", {wait_o, dq_oe}, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int starts[5] = '{0, 2, 7, 13, 254};
    rst_n = 1'b0; ce_n = 1'b1; adv_n = 1'b1; addr = '0; cfg_we = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset config", cfg_rdata, 16'h980F);
    chk("R1 reset err", cfg_err, 1'b0);
    chk("R1 reset outputs", {wait_o, dq_oe}, 2'b00);
    chk("R1 reset dq", dq_out, 16'h0000);

    // R2: reserved bits dropped
    write_cfg(16'h44F0 | cfgv(0, 2, 0, 0, 0, 1));
    chk("R2 reserved read zero", cfg_rdata, cfgv(0, 2, 0, 0, 0, 1));
    chk("R2 err clear", cfg_err, 1'b0);
    write_cfg(cfgv(1, 5, 1, 1, 1, 3));
    chk("R2 kept bits stored", cfg_rdata, cfgv(1, 5, 1, 1, 1, 3));

    // R3: refused writes
    write_cfg(cfgv(0, 5, 0, 0, 0, 1));
    write_cfg(cfgv(0, 1, 0, 0, 0, 1));
    chk("R3 bad latency keeps cfg", cfg_rdata, cfgv(0, 5, 0, 0, 0, 1));
    chk("R3 bad latency err", cfg_err, 1'b1);
    write_cfg(cfgv(0, 6, 0, 0, 0, 1));
    chk("R3 latency 6 refused", cfg_rdata, cfgv(0, 5, 0, 0, 0, 1));
    write_cfg(cfgv(0, 3, 0, 0, 0, 4));
    chk("R3 bad length keeps cfg", cfg_rdata, cfgv(0, 5, 0, 0, 0, 1));
    write_cfg(cfgv(0, 2, 1, 1, 0, 1));
    chk("R3 unsupported combo keeps cfg", cfg_rdata, cfgv(0, 5, 0, 0, 0, 1));
    chk("R3 unsupported combo err", cfg_err, 1'b1);
    run_burst(9, 5, 0, 0, 1, 4);
    chk("R3 err still set", cfg_err, 1'b1);
    write_cfg(cfgv(0, 2, 1, 0, 0, 1));
    chk("R3 accepted write clears err", cfg_err, 1'b0);

    // R4 R5 R6 R11 sweep
    for (int lat = 2; lat <= 5; lat++)
      for (int wrap = 0; wrap <= 1; wrap++)
        for (int bl = 1; bl <= 3; bl++)
          foreach (starts[i]) begin
            write_cfg(cfgv(0, lat, 0, 0, wrap, bl));
            run_burst(starts[i], lat, 0, wrap, bl, len_of(bl));
          end

    // R8 two-clock hold
    write_cfg(cfgv(0, 2, 1, 0, 0, 2));
    run_burst(5, 2, 1, 0, 2, 8);
    write_cfg(cfgv(0, 3, 1, 1, 1, 1));
    run_burst(30, 3, 1, 1, 1, 4);

    // R7 continuous, crosses address top, wrap bit ignored
    write_cfg(cfgv(0, 4, 0, 0, 0, 7));
    run_burst(250, 4, 0, 0, 7, 24);

    // R10 restart mid-burst
    write_cfg(cfgv(0, 3, 0, 0, 1, 3));
    strobe(16);
    expect_latency(3);
    expect_word("R10 first burst word", 16, 0);
    expect_word("R10 first burst word", 17, 0);
    adv_n = 1'b0; addr = 8'h80;
    @(negedge clk);
    adv_n = 1'b1; addr = 8'h11;
    chk("R10 restart raises wait", {wait_o, dq_oe}, 2'b10);
    for (int j = 1; j < 3; j++) begin
      @(negedge clk);
      chk("R10 restart latency", {wait_o, dq_oe}, 2'b10);
    end
    for (int k = 0; k < 4; k++) expect_word("R10 new address words", 128 + k, 0);
    ce_n = 1'b1;
    @(negedge clk);

    // R9 page mode, length field ignored
    write_cfg(cfgv(1, 4, 0, 0, 1, 1));
    strobe(8'h37);
    expect_latency(4);
    for (int r = 0; r < 3; r++)
      for (int a = 0; a < 4; a++) begin
        @(negedge clk);
        addr = AW'((8'hC0) | a);
        #1;
        chk("R9 page word", {wait_o, dq_oe}, 2'b01);
        chk("R9 page word data", dq_out, word_of((8'h37 & 8'hFC) | a));
      end
    ce_n = 1'b1;
    @(negedge clk);
    chk("R9 page ends on chip enable", {wait_o, dq_oe}, 2'b00);

    // R11 direct spot value
    chk("R11 word formula", word_of(1), 16'(40503) ^ 16'hC3A5);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule